// File: doc/BRIEF.md
# Sync-Word Gated Receive FIFO

This block sits behind a demodulator. It takes the recovered serial bit stream, one bit per strobe, and looks in that stream for a synchronisation word. Once it finds the word, it packs the bits that follow into bytes, most significant bit first. It stores those bytes in a small FIFO, and a host drains them through a show-ahead byte port.

One 16-bit command word sets the block up, and a separate register holds the programmable low sync byte. The command word selects four things:
- whether filling waits for a two-byte word (a fixed high byte of 2Dh followed by the programmable byte) or a one-byte word (the programmable byte alone), or starts without any match;
- whether filling is enabled at all;
- whether incoming bits are accepted;
- the bit count at which the interrupt is raised.

A status output shows when the block is actively filling. A sticky flag reports bits lost because the FIFO was full.

Top module: `rx_sync_fifo`

## Requirements
- R1: After reset the command word is CA80h, so the interrupt level is 8, the sync word has two bytes, filling is sync-gated and disabled, and bit reception is off. The low sync byte is D4h. In this state `irq`, `filling` and `ovf` are 0, and `rd_data` reads 00h.
- R2: A command write takes effect only when `cfg_data[15:8]` equals CAh. A write with any other value in those bits changes nothing.
- R3: In the command word, bits 7..4 hold the interrupt level, bit 3 selects the sync length (0 = two bytes, 1 = one byte), bit 2 selects always-fill, bit 1 enables filling and bit 0 enables bit reception. While bit 0 is 0, bit strobes are ignored.
- R4: With bit 3 = 0 and bit 2 = 0, filling starts with the first bit after the last 16 strobed bits, taken MSB-first, have equalled 2Dh followed by the low sync byte. The sync bits themselves are not stored.
- R5: With bit 3 = 1 and bit 2 = 0, filling starts after the last 8 strobed bits have equalled the low sync byte.
- R6: With bits 2 and 1 both set, `filling` is 1 at once and every accepted bit is stored.
- R7: Stored bits are packed MSB-first into bytes, and the FIFO holds up to 16 bytes. `rd_data` shows the oldest byte, and `rd_stb` removes it. A read of an empty FIFO is ignored, and `rd_data` reads 00h while the FIFO is empty.
- R8: `irq` is 1 exactly while 8 × (stored bytes) plus (bits in the partial byte) is at least the interrupt level. It stays 1 until reads bring that count below the level.
- R9: Every accepted command write re-arms the sync search. A write that clears bit 1 stops filling and discards any partial byte.
- R10: While the FIFO holds 16 bytes, bits that would be stored are dropped and `ovf` is set. `ovf` stays 1 until reset.
- R11: A pulse on `sync_we` loads `sync_data` as the low sync byte used by later matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Command word write strobe |
| cfg_data | input | 16 | Command word |
| sync_we | input | 1 | Low sync byte write strobe |
| sync_data | input | 8 | Low sync byte value |
| bit_stb | input | 1 | One-cycle strobe marking a valid received bit |
| bit_in | input | 1 | Received bit |
| rd_stb | input | 1 | Remove the byte shown on rd_data |
| rd_data | output | 8 | Oldest stored byte, 00h when empty |
| irq | output | 1 | Bit count has reached the interrupt level |
| filling | output | 1 | Received bits are currently being stored |
| ovf | output | 1 | Sticky overflow flag |

## Verification
A sync matcher that is misaligned or shifted the wrong way shows up as `filling` rising one bit too early, one bit too late or never. The bench therefore samples `filling` both on the second-to-last sync bit and on the last one. A fault in the packer or the FIFO pointers shows up on the next read as a wrong byte, or as a wrong order across the 16-entry fill. A bit-count error moves the `irq` edge by a bit or more. Each of these faults becomes visible within one strobe or one read after it occurs.

// File: rtl/rx_sync_fifo.sv
module rx_sync_fifo #(
  parameter int          DEPTH   = 16,
  parameter logic [7:0]  SYNC_HI = 8'h2D,
  parameter logic [7:0]  SYNC_LO = 8'hD4,
  parameter logic [15:0] CMD_RST = 16'hCA80
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [15:0] cfg_data,
  input  logic        sync_we,
  input  logic [7:0]  sync_data,
  input  logic        bit_stb,
  input  logic        bit_in,
  input  logic        rd_stb,
  output logic [7:0]  rd_data,
  output logic        irq,
  output logic        filling,
  output logic        ovf
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int BW = $clog2(DEPTH * 8 + 1);
  localparam logic [7:0] PREFIX = CMD_RST[15:8];

  logic [7:0]    cmd;
  logic [7:0]    sync_lo;
  logic [15:0]   shreg;
  logic          locked;
  logic [6:0]    pk;
  logic [2:0]    pk_n;
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  wire [3:0]  lvl     = cmd[7:4];
  wire        one_b   = cmd[3];
  wire        alw     = cmd[2];
  wire        fill_en = cmd[1];
  wire        rx_en   = cmd[0];

  wire        cmd_ok  = cfg_we && (cfg_data[15:8] == PREFIX);
  wire        stb     = bit_stb && rx_en;
  wire [15:0] sh_nx   = {shreg[14:0], bit_in};
  wire        hit     = one_b ? (sh_nx[7:0] == sync_lo) : (sh_nx == {SYNC_HI, sync_lo});
  wire        full    = (cnt == CW'(DEPTH));
  wire        take    = stb && filling && !full;
  wire        push    = take && (pk_n == 3'd7);
  wire        pop     = rd_stb && (cnt != '0);
  wire [BW-1:0] bits  = (BW'(cnt) << 3) + BW'(pk_n);

  assign filling = fill_en && (alw || locked);
  assign irq     = bits >= BW'(lvl);
  assign rd_data = (cnt != '0) ? mem[rp] : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd     <= CMD_RST[7:0];
      sync_lo <= SYNC_LO;
    end else begin
      if (cmd_ok)  cmd     <= cfg_data[7:0];
      if (sync_we) sync_lo <= sync_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg  <= '0;
      locked <= 1'b0;
    end else begin
      if (stb) shreg <= sh_nx;
      if (cmd_ok)
        locked <= 1'b0;
      else if (stb && fill_en && !alw && !locked && hit)
        locked <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pk   <= '0;
      pk_n <= '0;
    end else if (cmd_ok && !cfg_data[1]) begin
      pk   <= '0;
      pk_n <= '0;
    end else if (take) begin
      pk   <= {pk[5:0], bit_in};
      pk_n <= pk_n + 3'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= {pk, bit_in};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
      ovf <= 1'b0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
      if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
      cnt <= cnt + CW'(push) - CW'(pop);
      if (stb && filling && full) ovf <= 1'b1;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH)); // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf); // R10
  AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(rd_stb || cfg_we)); // R8
  AST_LOCK_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(bit_stb && rx_en && fill_en)); // R4
  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && cnt == '0 && !bit_stb) |=> (cnt == '0)); // R7
  AST_BAD_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_data[15:8] != PREFIX) |=> $stable(cmd)); // R2
  AST_RX_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && !rx_en && !cfg_we) |=> $stable(pk_n)); // R3
endmodule

// File: tb/sim_rx_sync_fifo.sv
module sim_rx_sync_fifo;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [15:0] cfg_data = '0;
  logic sync_we = 1'b0;
  logic [7:0] sync_data = '0;
  logic bit_stb = 1'b0;
  logic bit_in = 1'b0;
  logic rd_stb = 1'b0;
  logic [7:0] rd_data;
  logic irq, filling, ovf;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;
  logic [7:0] expq[$];

  always #4 clk = ~clk;

  rx_sync_fifo u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_data(cfg_data),
    .sync_we(sync_we), .sync_data(sync_data), .bit_stb(bit_stb), .bit_in(bit_in),
    .rd_stb(rd_stb), .rd_data(rd_data), .irq(irq), .filling(filling), .ovf(ovf)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FIFO FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic write_cmd(input logic [15:0] w);
    @(negedge clk); cfg_we = 1'b1; cfg_data = w;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic write_sync(input logic [7:0] b);
    @(negedge clk); sync_we = 1'b1; sync_data = b;
    @(negedge clk); sync_we = 1'b0;
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); bit_stb = 1'b1; bit_in = b;
    @(negedge clk); bit_stb = 1'b0;
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) send_bit(b[i]);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit stored);
    send_bits(b, 8);
    if (stored) expq.push_back(b);
  endtask

  task automatic read_check(input string req);
    logic [7:0] e;
    @(negedge clk);
    e = (expq.size() == 0) ? 8'h00 : expq.pop_front();
    chk(req, {8'h00, rd_data}, {8'h00, e});
    rd_stb = 1'b1;
    @(negedge clk); rd_stb = 1'b0;
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FIFO FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq", {15'd0, irq}, 16'd0);
    chk("R1 filling", {15'd0, filling}, 16'd0);
    chk("R1 ovf", {15'd0, ovf}, 16'd0);
    chk("R1 rd_data", {8'h00, rd_data}, 16'h0000);

    write_cmd(16'h12F6);
    chk("R2 bad prefix ignored", {15'd0, filling}, 16'd0);

    write_cmd(16'hCA87);
    chk("R6 always fill", {15'd0, filling}, 16'd1);
    send_bits(8'hA5, 7);
    chk("R8 irq below level", {15'd0, irq}, 16'd0);
    send_bit(1'b1);
    expq.push_back(8'hA5);
    chk("R8 irq at level", {15'd0, irq}, 16'd1);
    read_check("R7 byte A5");
    chk("R8 irq after read", {15'd0, irq}, 16'd0);

    read_check("R7 empty read");
    send_byte(8'h11, 1);
    read_check("R7 byte after empty read");

    write_cmd(16'hCA86);
    send_byte(8'hFF, 0);
    chk("R3 rx disabled irq", {15'd0, irq}, 16'd0);
    read_check("R3 rx disabled nothing stored");

    write_cmd(16'hCA83);
    chk("R4 idle before sync", {15'd0, filling}, 16'd0);
    send_byte(8'hFF, 0);
    send_byte(8'h2D, 0);
    send_bits(8'hD4, 7);
    chk("R4 not yet synced", {15'd0, filling}, 16'd0);
    send_bit(1'b0);
    chk("R4 synced", {15'd0, filling}, 16'd1);
    send_byte(8'h3C, 1);
    read_check("R4 first byte after sync");

    send_bits(8'hA0, 4);
    write_cmd(16'hCA81);
    chk("R9 fill stopped", {15'd0, filling}, 16'd0);
    write_cmd(16'hCA83);
    chk("R9 search re-armed", {15'd0, filling}, 16'd0);
    write_cmd(16'hCA87);
    send_byte(8'h5A, 1);
    read_check("R9 partial discarded");

    write_sync(8'h96);
    write_cmd(16'hCA8B);
    chk("R5 idle before sync", {15'd0, filling}, 16'd0);
    send_byte(8'h00, 0);
    send_bits(8'h96, 7);
    chk("R11 not yet synced", {15'd0, filling}, 16'd0);
    send_bit(1'b0);
    chk("R5 one-byte sync with R11 byte", {15'd0, filling}, 16'd1);
    send_byte(8'hC3, 1);
    read_check("R5 byte after sync");

    write_cmd(16'hCA37);
    send_bits(8'hC0, 2);
    chk("R8 level 3 below", {15'd0, irq}, 16'd0);
    send_bit(1'b1);
    chk("R8 level 3 reached", {15'd0, irq}, 16'd1);
    write_cmd(16'hCA35);
    chk("R9 partial cleared irq", {15'd0, irq}, 16'd0);

    write_cmd(16'hCAF7);
    for (int k = 0; k < 16; k++) send_byte(8'((k * 37) ^ 8'h5C), 1);
    chk("R8 irq full", {15'd0, irq}, 16'd1);
    chk("R10 no ovf yet", {15'd0, ovf}, 16'd0);
    send_byte(8'hEE, 0);
    chk("R10 ovf set", {15'd0, ovf}, 16'd1);
    for (int k = 0; k < 16; k++) read_check("R10 stored order");
    chk("R10 ovf sticky", {15'd0, ovf}, 16'd1);
    chk("R8 irq after drain", {15'd0, irq}, 16'd0);
    read_check("R7 empty after drain");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule